// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This unit is the processor-facing side of an interrupt controller for one CPU. It takes the arbiter's current best candidate (its ID, its priority and a flag saying whether the source is shared by all CPUs) and filters it through an enable bit and a priority mask. It then serves a small register window through which software claims interrupts and later retires them.

Claiming an interrupt makes it the running one and remembers, in a per-ID link, which interrupt it preempted. Retiring the running interrupt follows that link back, restoring both the ID and its priority. Software may also retire an interrupt that is buried in the middle of the preemption stack. In that case the unit walks the link chain one step per cycle, holds the bus busy while it walks, and splices the retired entry out. Pending-clear and re-pend requests leave the unit as one-cycle strobes to the distributor, which owns the pending state.

Top module: `ack_eoi_unit`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0x100, the mask reads 0, the enable reads 0 and the pending view at 0x18 reads 1023.
- R2: Offset 0x00 holds the enable in bit 0. Offset 0x04 holds an 8-bit mask, and the upper write bits are dropped. Offset 0x08 reads 0 and ignores writes. Any offset outside the window reads 0.
- R3: Offset 0x18 reads the candidate ID only when the unit is enabled, the ID is not 1023 and its priority is strictly below the mask. Otherwise it reads 1023.
- R4: A read of 0x0C returns 1023 and changes no state when the pending view is 1023 or the candidate priority is not strictly below the running priority.
- R5: A successful read of 0x0C returns the candidate ID. The running ID and priority become the candidate's, and one cycle later a pending-clear strobe carries the ID, with the all-CPU flag equal to the candidate's shared flag.
- R6: A write to 0x10 uses only bits 9:0. It is ignored when that ID is at or above NUM_SRC, or when the running ID is 1023.
- R7: Retiring the running ID restores the ID it preempted, together with that ID's priority. If it preempted nothing, the result is 1023 and 0x100.
- R8: Retiring a non-running ID holds busy high for one cycle per link followed. When the ID is found, it is removed from the chain; otherwise nothing changes. The running ID stays put throughout.
- R9: Every accepted completion raises, one cycle later, a re-pend strobe that carries the retired ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access request, held until accepted (busBusy low) |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset in the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the accepting cycle |
| busBusy | output | 1 | Chain walk in progress; requests are not accepted |
| hpId | input | 10 | Arbiter's best pending ID (1023 = none) |
| hpPrio | input | 8 | Priority of hpId (lower is more urgent) |
| hpShared | input | 1 | hpId is a source shared across CPUs |
| pendClrValid | output | 1 | Pending-clear strobe |
| pendClrId | output | 10 | ID to clear |
| pendClrAll | output | 1 | Clear for all CPUs |
| rependValid | output | 1 | Re-pend request strobe |
| rependId | output | 10 | Completed ID to re-evaluate |
| runId | output | 10 | Running interrupt ID |
| runPrio | output | 9 | Running priority (0x100 = idle) |

## Verification
A corrupted link shows up at the ports only at completion time. The unit then returns to a wrong ID or priority on runId and runPrio in the cycle after the write, or the busy window takes a different length. The bench therefore builds a three-deep stack, unlinks the middle entry and a missing entry while counting busy cycles, and then unwinds the stack, checking every restored ID and priority. A stale running priority appears on the very next claim attempt, as an acknowledge that is wrongly accepted or wrongly refused.

// File: rtl/ack_eoi_pkg.sv
package ack_eoi_pkg;
  localparam int ID_W = 10;
  localparam int PRIO_W = 8;
  localparam logic [ID_W-1:0] IDLE_ID = 10'd1023;
  localparam logic [PRIO_W:0] IDLE_PRIO = 9'h100;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_MASK = 8'h04;
  localparam logic [7:0] OFF_BPT  = 8'h08;
  localparam logic [7:0] OFF_ACK  = 8'h0C;
  localparam logic [7:0] OFF_EOI  = 8'h10;
  localparam logic [7:0] OFF_RPRI = 8'h14;
  localparam logic [7:0] OFF_HPND = 8'h18;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic ack;
    logic eoiRun;
    logic walkLoad;
    logic walkStep;
    logic repend;
  } strobe_t;
endpackage

// File: rtl/ack_eoi_ctrl.sv
module ack_eoi_ctrl
  import ack_eoi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busValid,
  input  logic       busWrite,
  input  logic [7:0] busAddr,
  input  logic       ackOk,
  input  logic       eoiValid,
  input  logic       eoiIsRun,
  input  logic       walkDone,
  output strobe_t    strobe,
  output logic       busBusy
);
  typedef enum logic {ST_IDLE, ST_WALK} state_e;
  state_e state, stateNxt;
  logic accept;

  always_comb begin
    strobe = '0;
    stateNxt = state;
    busBusy = (state == ST_WALK);
    accept = busValid && (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (accept && busWrite) begin
          case (busAddr)
            OFF_CTRL: strobe.wrCtrl = 1'b1;
            OFF_MASK: strobe.wrMask = 1'b1;
            OFF_EOI: begin
              if (eoiValid) begin
                strobe.repend = 1'b1;
                if (eoiIsRun) begin
                  strobe.eoiRun = 1'b1;
                end else begin
                  strobe.walkLoad = 1'b1;
                  stateNxt = ST_WALK;
                end
              end
            end
            default: ;
          endcase
        end else if (accept && busAddr == OFF_ACK && ackOk) begin
          strobe.ack = 1'b1;
        end
      end
      ST_WALK: begin
        strobe.walkStep = 1'b1;
        if (walkDone) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/ack_eoi_data.sv
module ack_eoi_data
  import ack_eoi_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [ID_W-1:0]   hpId,
  input  logic [PRIO_W-1:0] hpPrio,
  input  logic              hpShared,
  output logic              ackOk,
  output logic              eoiValid,
  output logic              eoiIsRun,
  output logic              walkDone,
  output logic              pendClrValid,
  output logic [ID_W-1:0]   pendClrId,
  output logic              pendClrAll,
  output logic              rependValid,
  output logic [ID_W-1:0]   rependId,
  output logic [ID_W-1:0]   runId,
  output logic [PRIO_W:0]   runPrio
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic              enable;
  logic [PRIO_W-1:0] prioMask;
  logic [ID_W-1:0]   link [NUM_SRC];
  logic [PRIO_W-1:0] actPrio [NUM_SRC];
  logic [ID_W-1:0]   cursor, target;
  logic [ID_W-1:0]   hpView, eoiId, curLink, prevId;
  logic              linkHit, linkEnd;

  function automatic logic [IDX_W-1:0] toIdx(input logic [ID_W-1:0] id);
    return id[IDX_W-1:0];
  endfunction

  assign hpView = (enable && hpId != IDLE_ID && 32'(hpId) < NUM_SRC && hpPrio < prioMask)
                  ? hpId : IDLE_ID;
  assign ackOk = (hpView != IDLE_ID) && ({1'b0, hpPrio} < runPrio);
  assign eoiId = busWdata[ID_W-1:0];
  assign eoiValid = (32'(eoiId) < NUM_SRC) && (runId != IDLE_ID);
  assign eoiIsRun = (eoiId == runId);
  assign curLink = link[toIdx(cursor)];
  assign linkHit = (curLink == target);
  assign linkEnd = (curLink == IDLE_ID);
  assign walkDone = linkHit || linkEnd;
  assign prevId = link[toIdx(runId)];

  always_comb begin
    case (busAddr)
      OFF_CTRL: busRdata = {31'd0, enable};
      OFF_MASK: busRdata = {24'd0, prioMask};
      OFF_ACK:  busRdata = {22'd0, ackOk ? hpView : IDLE_ID};
      OFF_RPRI: busRdata = {23'd0, runPrio};
      OFF_HPND: busRdata = {22'd0, hpView};
      default:  busRdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= 1'b0;
      prioMask <= '0;
      runId <= IDLE_ID;
      runPrio <= IDLE_PRIO;
      cursor <= IDLE_ID;
      target <= IDLE_ID;
      pendClrValid <= 1'b0;
      pendClrId <= IDLE_ID;
      pendClrAll <= 1'b0;
      rependValid <= 1'b0;
      rependId <= IDLE_ID;
      for (int i = 0; i < NUM_SRC; i++) begin
        link[i] <= IDLE_ID;
        actPrio[i] <= '0;
      end
    end else begin
      pendClrValid <= strobe.ack;
      rependValid <= strobe.repend;
      if (strobe.ack) begin
        pendClrId <= hpId;
        pendClrAll <= hpShared;
      end
      if (strobe.repend) rependId <= eoiId;
      if (strobe.wrCtrl) enable <= busWdata[0];
      if (strobe.wrMask) prioMask <= busWdata[PRIO_W-1:0];
      if (strobe.ack) begin
        link[toIdx(hpId)] <= runId;
        actPrio[toIdx(hpId)] <= hpPrio;
        runId <= hpId;
        runPrio <= {1'b0, hpPrio};
      end
      if (strobe.eoiRun) begin
        runId <= prevId;
        runPrio <= (prevId == IDLE_ID) ? IDLE_PRIO : {1'b0, actPrio[toIdx(prevId)]};
      end
      if (strobe.walkLoad) begin
        cursor <= runId;
        target <= eoiId;
      end
      if (strobe.walkStep) begin
        if (linkHit) link[toIdx(cursor)] <= link[toIdx(target)];
        else if (!linkEnd) cursor <= curLink;
      end
    end
  end
endmodule

// File: rtl/ack_eoi_unit.sv
module ack_eoi_unit
  import ack_eoi_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        busBusy,
  input  logic [9:0]  hpId,
  input  logic [7:0]  hpPrio,
  input  logic        hpShared,
  output logic        pendClrValid,
  output logic [9:0]  pendClrId,
  output logic        pendClrAll,
  output logic        rependValid,
  output logic [9:0]  rependId,
  output logic [9:0]  runId,
  output logic [8:0]  runPrio
);
  strobe_t strobe;
  logic ackOk, eoiValid, eoiIsRun, walkDone;

  ack_eoi_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .ackOk(ackOk), .eoiValid(eoiValid),
    .eoiIsRun(eoiIsRun), .walkDone(walkDone), .strobe(strobe),
    .busBusy(busBusy)
  );

  ack_eoi_data #(.NUM_SRC(NUM_SRC)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .hpId(hpId), .hpPrio(hpPrio),
    .hpShared(hpShared), .ackOk(ackOk), .eoiValid(eoiValid),
    .eoiIsRun(eoiIsRun), .walkDone(walkDone), .pendClrValid(pendClrValid),
    .pendClrId(pendClrId), .pendClrAll(pendClrAll), .rependValid(rependValid),
    .rependId(rependId), .runId(runId), .runPrio(runPrio)
  );
endmodule

// File: rtl/ack_eoi_checks.sv
module ack_eoi_checks #(
  parameter int NUM_SRC = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       busValid,
  input logic       busWrite,
  input logic [7:0] busAddr,
  input logic       busBusy,
  input logic       pendClrValid,
  input logic [9:0] pendClrId,
  input logic       rependValid,
  input logic [9:0] rependId,
  input logic [9:0] runId,
  input logic [8:0] runPrio
);
  // R1 / R7: idle ID and idle priority always travel together
  a_r7_idle_pair: assert property (@(posedge clk) disable iff (!rstN)
    (runId == 10'd1023) == (runPrio == 9'h100));

  // R5: a pending-clear strobe names the interrupt that is now running
  a_r5_clear_is_running: assert property (@(posedge clk) disable iff (!rstN)
    pendClrValid |-> runId == pendClrId);

  // R8: the running ID holds still while the chain is walked
  a_r8_walk_keeps_run: assert property (@(posedge clk) disable iff (!rstN)
    busBusy && $past(busBusy) |-> $stable(runId));

  // R8: busy only starts after a completion write
  a_r8_busy_from_eoi: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusy) |-> $past(busValid && busWrite && busAddr == 8'h10));

  // R9: re-pend only names implemented sources
  a_r9_repend_range: assert property (@(posedge clk) disable iff (!rstN)
    rependValid |-> 32'(rependId) < NUM_SRC);
endmodule

bind ack_eoi_unit ack_eoi_checks #(.NUM_SRC(NUM_SRC)) checks_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busBusy(busBusy), .pendClrValid(pendClrValid),
  .pendClrId(pendClrId), .rependValid(rependValid), .rependId(rependId),
  .runId(runId), .runPrio(runPrio)
);

// File: tb/ack_eoi_unit_tb_top.sv
module ack_eoi_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busBusy;
  logic [9:0] hpId = 10'd1023;
  logic [7:0] hpPrio = '0;
  logic hpShared = 1'b0;
  logic pendClrValid, pendClrAll, rependValid;
  logic [9:0] pendClrId, rependId, runId;
  logic [8:0] runPrio;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] rd;
  logic sClrV, sClrAll, sRepV;
  logic [9:0] sClrId, sRepId;
  int busyCyc;

  always #2 clk = ~clk;

  ack_eoi_unit #(.NUM_SRC(64)) dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busBusy(busBusy), .hpId(hpId), .hpPrio(hpPrio), .hpShared(hpShared),
    .pendClrValid(pendClrValid), .pendClrId(pendClrId), .pendClrAll(pendClrAll),
    .rependValid(rependValid), .rependId(rependId), .runId(runId), .runPrio(runPrio)
  );

  typedef struct packed {
    logic        chk;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [9:0]  id;
    logic [7:0]  prio;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 1'b0, 8'h00, 32'h0,   10'd5,    8'h10, 32'd0},    // R1 disabled
    '{1'b1, 1'b0, 8'h04, 32'h0,   10'd5,    8'h10, 32'd0},    // R1 mask 0
    '{1'b1, 1'b0, 8'h18, 32'h0,   10'd5,    8'h10, 32'd1023}, // R1/R3 disabled view
    '{1'b0, 1'b1, 8'h00, 32'h3,   10'd5,    8'h10, 32'd0},
    '{1'b1, 1'b0, 8'h00, 32'h0,   10'd5,    8'h10, 32'd1},    // R2 enable bit
    '{1'b0, 1'b1, 8'h04, 32'h1F0, 10'd5,    8'h10, 32'd0},
    '{1'b1, 1'b0, 8'h04, 32'h0,   10'd5,    8'h10, 32'hF0},   // R2 8-bit mask
    '{1'b0, 1'b1, 8'h08, 32'h7,   10'd5,    8'h10, 32'd0},
    '{1'b1, 1'b0, 8'h08, 32'h0,   10'd5,    8'h10, 32'd0},    // R2 reads zero
    '{1'b1, 1'b0, 8'h18, 32'h0,   10'd5,    8'h10, 32'd5},    // R3 visible
    '{1'b1, 1'b0, 8'h18, 32'h0,   10'd5,    8'hF0, 32'd1023}, // R3 not below mask
    '{1'b1, 1'b0, 8'h1C, 32'h0,   10'd5,    8'h10, 32'd0}     // R2 unmapped
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busWdata = data;
    #1 rd = busRdata;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    sClrV = pendClrValid; sClrId = pendClrId; sClrAll = pendClrAll;
    sRepV = rependValid; sRepId = rependId;
    busyCyc = 0;
    while (busBusy) begin
      busyCyc++;
      @(negedge clk);
    end
  endtask

  task automatic setHp(input logic [9:0] id, input logic [7:0] p, input logic sh);
    hpId = id; hpPrio = p; hpShared = sh;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 runId", 32'(runId), 32'd1023);
    check("R1 runPrio", 32'(runPrio), 32'h100);
    for (int i = 0; i < 12; i++) begin
      setHp(VECS[i].id, VECS[i].prio, 1'b0);
      op(VECS[i].wr, VECS[i].addr, VECS[i].wdata);
      if (VECS[i].chk) check($sformatf("R1/R2/R3 vector %0d", i), rd, VECS[i].exp);
    end
    op(1'b1, 8'h04, 32'hFF);
    op(1'b0, 8'h14, 0);
    check("R1 running priority read", rd, 32'h100);

    // R6: completion while idle is ignored
    op(1'b1, 8'h10, 32'd5);
    check("R6 idle eoi no repend", 32'(sRepV), 32'd0);
    check("R6 idle eoi runId", 32'(runId), 32'd1023);

    // R4: pending view none
    setHp(10'd1023, 8'h10, 1'b0);
    op(1'b0, 8'h0C, 0);
    check("R4 ack none", rd, 32'd1023);
    check("R4 no clear strobe", 32'(sClrV), 32'd0);

    // R5: build stack 5(0x40) <- 9(0x20) <- 12(0x10)
    setHp(10'd5, 8'h40, 1'b0);
    op(1'b0, 8'h0C, 0);
    check("R5 ack id", rd, 32'd5);
    check("R5 clear strobe", {sClrV, sClrAll, 20'd0, sClrId}, {1'b1, 1'b0, 20'd0, 10'd5});
    check("R5 runPrio", 32'(runPrio), 32'h40);
    setHp(10'd9, 8'h20, 1'b1);
    op(1'b0, 8'h0C, 0);
    check("R5 ack nested", rd, 32'd9);
    check("R5 shared clear", {sClrV, sClrAll, 20'd0, sClrId}, {1'b1, 1'b1, 20'd0, 10'd9});
    setHp(10'd12, 8'h10, 1'b0);
    op(1'b0, 8'h0C, 0);
    check("R5 ack third", rd, 32'd12);

    // R4: equal priority is refused
    setHp(10'd3, 8'h10, 1'b0);
    op(1'b0, 8'h0C, 0);
    check("R4 equal prio refused", rd, 32'd1023);
    check("R4 runId kept", 32'(runId), 32'd12);
    setHp(10'd1023, 8'h00, 1'b0);

    // R8: unlink middle entry 9 (one link followed)
    op(1'b1, 8'h10, 32'd9);
    check("R8 splice busy cycles", busyCyc, 1);
    check("R8 runId after splice", 32'(runId), 32'd12);
    check("R9 repend id", {sRepV, 21'd0, sRepId}, {1'b1, 21'd0, 10'd9});

    // R8: id not in chain, two links followed
    op(1'b1, 8'h10, 32'd7);
    check("R8 miss busy cycles", busyCyc, 2);
    check("R8 miss runId", 32'(runId), 32'd12);

    // R7: retire running 12, must return to 5 (9 was spliced out)
    op(1'b1, 8'h10, 32'd12);
    check("R7 restore id", 32'(runId), 32'd5);
    check("R7 restore prio", 32'(runPrio), 32'h40);
    check("R9 repend running", {sRepV, 21'd0, sRepId}, {1'b1, 21'd0, 10'd12});

    // R6: out-of-range id ignored while running
    op(1'b1, 8'h10, 32'd64);
    check("R6 range runId", 32'(runId), 32'd5);
    check("R6 range no repend", 32'(sRepV), 32'd0);

    // R6: value masked to 10 bits -> completes 5
    op(1'b1, 8'h10, 32'h405);
    check("R6 masked eoi id", 32'(runId), 32'd1023);
    check("R7 idle prio", 32'(runPrio), 32'h100);

    // R3: priority mask blocks candidate
    op(1'b1, 8'h04, 32'h30);
    setHp(10'd20, 8'h30, 1'b0);
    op(1'b0, 8'h0C, 0);
    check("R3 masked ack", rd, 32'd1023);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule